// File: doc/BRIEF.md
# Fast A20 and Alternate Reset Control Port

This block is a one-byte system control port on a simple host I/O bus. The host supplies an already decoded select, a write strobe, a read strobe and write data. Two bits of the port matter.

Bit 1 holds an alternate A20 gate. That gate is ORed with the keyboard controller's A20 gate to form the CPU address-20 mask output.

Bit 0 requests a CPU reset. Writing a 1 to it while no request is pending starts a timed sequence: first a quiet delay, then an active-low reset pulse. That pulse is ANDed with the keyboard controller's active-low reset request to form one keyboard reset output.

An enable input takes the whole port off the bus. Both intervals are given in microseconds and turned into clock counts from the clock-frequency parameter. With the defaults, the delay is 14 µs and the pulse is 6 µs, which at 125 MHz is 1750 and 750 cycles.

Top module: `legacy_sysctl_port`

## Requirements
- R1: After reset, the stored A20 bit (bit 1) and request bit (bit 0) are both 0, `cpu_a20_out` follows `kbc_a20_gate`, and `kbd_rst_n` follows `kbc_rst_n`.
- R2: A write is accepted when `port_en`, `io_sel` and `io_wr` are all high at a rising clock edge. An accepted write stores `io_wdata[1]` as the alternate A20 bit and `io_wdata[0]` as the request bit, both visible from the next cycle.
- R3: `cpu_a20_out` is high whenever the stored A20 bit is high, whatever `kbc_a20_gate` is doing. It is low only when both are low. It is combinational from those two sources.
- R4: An accepted write with `io_wdata[0]`=1, made while no sequence runs, leaves `kbd_rst_n` high for DELAY_CYC cycles after the capturing edge. It then drives it low for exactly PULSE_CYC cycles and returns it high on a clock edge. DELAY_CYC = CLK_MHZ*DELAY_US and PULSE_CYC = CLK_MHZ*PULSE_US.
- R5: `kbd_rst_n` is low whenever `kbc_rst_n` is low or the alternate pulse is active, and high otherwise.
- R6: While `port_en` is low, writes change neither stored bit and start no reset sequence.
- R7: A read with `port_en`, `io_sel` and `io_rd` high returns, combinationally, bit 1 = stored A20 bit, bit 0 = stored request bit, all upper bits 0. While the port is disabled, read data carries no meaning.
- R8: A write with `io_wdata[0]`=1 accepted while a sequence is in its delay or pulse phase neither restarts nor extends that sequence. Its bit 1 value is still stored.
- R9: The parameters are checked when the design is elaborated. The data width must be at least 3, and both interval counts must be at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Port enable; low removes the port from the bus |
| io_sel | input | 1 | Decoded address hit for this port |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | DATA_W | Write data |
| io_rdata | output | DATA_W | Read data |
| kbc_a20_gate | input | 1 | A20 gate from the keyboard controller |
| kbc_rst_n | input | 1 | Active-low reset request from the keyboard controller |
| cpu_a20_out | output | 1 | Address-20 mask control to the CPU |
| kbd_rst_n | output | 1 | Merged active-low reset to the CPU |

## Verification
The A20 path is driven with all four combinations of stored bit and external gate. This separates a true OR from pass-through of either source or from an AND.

The reset sequence is measured edge by edge, once alone and once with further request writes landing in both the delay and the pulse phases. The measurement shows off-by-one faults in either interval, and it shows a retrigger as a shifted or second pulse.

Writes with the port disabled are followed by a long watch of the reset output and an enabled read-back. This tells an ignored write apart from one that leaks into storage or into the sequencer.

The external reset request is applied while the sequencer is idle, to confirm the AND merge.

// File: rtl/sysport_pkg.sv
package sysport_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_DELAY = 2'd1,
      SEQ_PULSE = 2'd2
   } seq_state_e;

   typedef struct packed {
      logic a20;
      logic req;
   } ctl_bits_t;

endpackage

// File: rtl/sysport_ctlreg.sv
module sysport_ctlreg
   import sysport_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              port_en,
   input  logic              io_sel,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [DATA_W-1:0] io_wdata,
   output logic [DATA_W-1:0] io_rdata,
   output ctl_bits_t         bits,
   output logic              start_req
);

   localparam int PAD_W = DATA_W - 2;

   // R9
   generate
      if (DATA_W < 3) begin : g_bad_width
         $error("sysport_ctlreg: DATA_W must be at least 3");
      end
   endgenerate

   logic wr_acc;
   logic rd_acc;

   assign wr_acc = port_en & io_sel & io_wr;
   assign rd_acc = port_en & io_sel & io_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bits <= '0;
      end else if (wr_acc) begin
         bits.a20 <= io_wdata[1];
         bits.req <= io_wdata[0];
      end
   end

   assign start_req = wr_acc & io_wdata[0];

   assign io_rdata = rd_acc ? {{PAD_W{1'b0}}, bits.a20, bits.req} : '0;

   // R1
   always @(posedge clk) begin
      if (!rst_n) begin
         reset_clear_chk: assert (bits == '0)
            else $error("control bits not clear in reset");
      end
   end

   // R2
   wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_acc |=> (bits.a20 == $past(io_wdata[1])) && (bits.req == $past(io_wdata[0])))
      else $error("accepted write not stored");

   // R6
   dis_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!port_en) |=> $stable(bits))
      else $error("bits changed while port disabled");

endmodule

// File: rtl/sysport_rst_seq.sv
module sysport_rst_seq
   import sysport_pkg::*;
#(
   parameter int DELAY_CYC = 1750,
   parameter int PULSE_CYC = 750
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic alt_rst_n,
   output logic busy
);

   localparam int MAX_CYC = (DELAY_CYC > PULSE_CYC) ? DELAY_CYC : PULSE_CYC;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);
   localparam logic [CNT_W-1:0] DELAY_LOAD = CNT_W'(DELAY_CYC - 1);
   localparam logic [CNT_W-1:0] PULSE_LOAD = CNT_W'(PULSE_CYC - 1);

   // R9
   generate
      if (DELAY_CYC < 1) begin : g_bad_delay
         $error("sysport_rst_seq: DELAY_CYC must be at least 1");
      end
      if (PULSE_CYC < 1) begin : g_bad_pulse
         $error("sysport_rst_seq: PULSE_CYC must be at least 1");
      end
   endgenerate

   seq_state_e        state;
   logic [CNT_W-1:0]  cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SEQ_IDLE;
         cnt   <= '0;
      end else begin
         unique case (state)
            SEQ_IDLE: begin
               if (start) begin
                  state <= SEQ_DELAY;
                  cnt   <= DELAY_LOAD;
               end
            end
            SEQ_DELAY: begin
               if (cnt == '0) begin
                  state <= SEQ_PULSE;
                  cnt   <= PULSE_LOAD;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            SEQ_PULSE: begin
               if (cnt == '0) begin
                  state <= SEQ_IDLE;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: begin
               state <= SEQ_IDLE;
               cnt   <= '0;
            end
         endcase
      end
   end

   assign busy      = (state != SEQ_IDLE);
   assign alt_rst_n = (state != SEQ_PULSE);

   // R4
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_IDLE && !start) |=> (state == SEQ_IDLE))
      else $error("sequencer left idle without a start");

   // R4
   pulse_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_PULSE) |=> (state == SEQ_PULSE || state == SEQ_IDLE))
      else $error("pulse phase left to a wrong state");

   // R8
   no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_DELAY && cnt != '0) |=> (state == SEQ_DELAY && cnt == $past(cnt) - 1'b1))
      else $error("delay phase disturbed");

endmodule

// File: rtl/legacy_sysctl_port.sv
module legacy_sysctl_port
   import sysport_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int CLK_MHZ  = 125,
   parameter int DELAY_US = 14,
   parameter int PULSE_US = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              port_en,
   input  logic              io_sel,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [DATA_W-1:0] io_wdata,
   output logic [DATA_W-1:0] io_rdata,
   input  logic              kbc_a20_gate,
   input  logic              kbc_rst_n,
   output logic              cpu_a20_out,
   output logic              kbd_rst_n
);

   localparam int DELAY_CYC = CLK_MHZ * DELAY_US;
   localparam int PULSE_CYC = CLK_MHZ * PULSE_US;

   // R9
   generate
      if (CLK_MHZ < 1) begin : g_bad_clk
         $error("legacy_sysctl_port: CLK_MHZ must be at least 1");
      end
   endgenerate

   ctl_bits_t bits;
   logic      start_req;
   logic      alt_rst_n;
   logic      seq_busy;

   sysport_ctlreg #(
      .DATA_W (DATA_W)
   ) u_ctlreg (
      .clk       (clk),
      .rst_n     (rst_n),
      .port_en   (port_en),
      .io_sel    (io_sel),
      .io_wr     (io_wr),
      .io_rd     (io_rd),
      .io_wdata  (io_wdata),
      .io_rdata  (io_rdata),
      .bits      (bits),
      .start_req (start_req)
   );

   sysport_rst_seq #(
      .DELAY_CYC (DELAY_CYC),
      .PULSE_CYC (PULSE_CYC)
   ) u_rst_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start_req),
      .alt_rst_n (alt_rst_n),
      .busy      (seq_busy)
   );

   assign cpu_a20_out = bits.a20 | kbc_a20_gate;
   assign kbd_rst_n   = kbc_rst_n & alt_rst_n;

   // R3
   a20_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bits.a20 |-> cpu_a20_out)
      else $error("A20 output low while stored bit high");

   // R5
   idle_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!seq_busy && kbc_rst_n) |-> kbd_rst_n)
      else $error("reset output low with no source");

endmodule

// File: tb/legacy_sysctl_port_bench.sv
module legacy_sysctl_port_bench;

   localparam int DATA_W    = 8;
   localparam int DLY       = 125 * 14;
   localparam int PLS       = 125 * 6;
   localparam int WATCHDOG  = 200000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              port_en = 1'b1;
   logic              io_sel = 1'b0;
   logic              io_wr = 1'b0;
   logic              io_rd = 1'b0;
   logic [DATA_W-1:0] io_wdata = '0;
   logic [DATA_W-1:0] io_rdata;
   logic              kbc_a20_gate = 1'b0;
   logic              kbc_rst_n = 1'b1;
   logic              cpu_a20_out;
   logic              kbd_rst_n;

   int n_vec  = 0;
   int n_fail = 0;

   logic [1:0] model_bits = 2'b00;

   logic [DATA_W-1:0] exp_q[$];
   string             tag_q[$];

   always #4 clk = ~clk;

   legacy_sysctl_port u_legacy_sysctl_port (
      .clk          (clk),
      .rst_n        (rst_n),
      .port_en      (port_en),
      .io_sel       (io_sel),
      .io_wr        (io_wr),
      .io_rd        (io_rd),
      .io_wdata     (io_wdata),
      .io_rdata     (io_rdata),
      .kbc_a20_gate (kbc_a20_gate),
      .kbc_rst_n    (kbc_rst_n),
      .cpu_a20_out  (cpu_a20_out),
      .kbd_rst_n    (kbd_rst_n)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: pops expected read data as the design presents it
   always @(posedge clk) begin
      #1;
      if (io_rd && io_sel && port_en) begin
         if (exp_q.size() == 0) begin
            check("R7 unexpected read", 32'(io_rdata), 32'hFFFF);
         end else begin
            automatic logic [DATA_W-1:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check(t, 32'(io_rdata), 32'(e));
         end
      end
   end

   task automatic do_write(input logic [DATA_W-1:0] d);
      @(negedge clk);
      io_sel = 1'b1; io_wr = 1'b1; io_wdata = d;
      if (port_en) model_bits = d[1:0];
      @(negedge clk);
      io_sel = 1'b0; io_wr = 1'b0; io_wdata = '0;
   endtask

   task automatic do_read(input string t);
      @(negedge clk);
      io_sel = 1'b1; io_rd = 1'b1;
      exp_q.push_back({{(DATA_W-2){1'b0}}, model_bits});
      tag_q.push_back(t);
      @(negedge clk);
      io_sel = 1'b0; io_rd = 1'b0;
   endtask

   // counts cycles from the current negedge; reports first low index and low count
   task automatic measure(input int n, output int first_low, output int low_cnt);
      first_low = -1;
      low_cnt   = 0;
      for (int i = 0; i < n; i++) begin
         if (kbd_rst_n == 1'b0) begin
            if (first_low < 0) first_low = i;
            low_cnt++;
         end
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      int fl;
      int lc;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 a20 out", 32'(cpu_a20_out), 32'd0);
      check("R1 rst out", 32'(kbd_rst_n), 32'd1);
      do_read("R1 R7 read after reset");

      // R3 external gate alone
      kbc_a20_gate = 1'b1; #1;
      check("R3 gate only", 32'(cpu_a20_out), 32'd1);
      kbc_a20_gate = 1'b0;

      // R2 R7 store bit 1
      do_write(8'hF2);
      check("R2 a20 set", 32'(cpu_a20_out), 32'd1);
      do_read("R2 R7 readback 0x02");
      kbc_a20_gate = 1'b1; #1;
      check("R3 both high", 32'(cpu_a20_out), 32'd1);
      kbc_a20_gate = 1'b0;
      do_write(8'h00);
      check("R2 a20 clear", 32'(cpu_a20_out), 32'd0);
      kbc_a20_gate = 1'b1; #1;
      check("R3 gate with bit low", 32'(cpu_a20_out), 32'd1);
      kbc_a20_gate = 1'b0; #1;
      check("R3 both low", 32'(cpu_a20_out), 32'd0);

      // R5 external reset request
      kbc_rst_n = 1'b0; #1;
      check("R5 kbc request", 32'(kbd_rst_n), 32'd0);
      kbc_rst_n = 1'b1; #1;
      check("R5 kbc release", 32'(kbd_rst_n), 32'd1);

      // R6 disabled writes
      @(negedge clk);
      port_en = 1'b0;
      do_write(8'h03);
      measure(DLY + PLS + 20, fl, lc);
      check("R6 no pulse when disabled", 32'(lc), 32'd0);
      check("R6 a20 untouched", 32'(cpu_a20_out), 32'd0);
      port_en = 1'b1;
      do_read("R6 R7 bits unchanged");

      // R4 plain sequence
      do_write(8'h01);
      measure(DLY + PLS + 50, fl, lc);
      check("R4 delay length", 32'(fl), 32'(DLY));
      check("R4 pulse length", 32'(lc), 32'(PLS));
      check("R4 released", 32'(kbd_rst_n), 32'd1);
      do_read("R7 request bit held");

      // R8 writes during delay and pulse phases
      do_write(8'h01);
      fork
         measure(DLY + PLS + 400, fl, lc);
         begin
            repeat (100) @(negedge clk);
            do_write(8'h03);
            repeat (DLY) @(negedge clk);
            do_write(8'h01);
         end
      join
      check("R8 delay not restarted", 32'(fl), 32'(DLY));
      check("R8 single pulse", 32'(lc), 32'(PLS));
      check("R8 a20 still stored", 32'(cpu_a20_out), 32'd0);
      do_read("R8 R7 readback");

      // R5 merge during pulse
      do_write(8'h01);
      repeat (DLY + 10) @(negedge clk);
      check("R5 pulse drives output", 32'(kbd_rst_n), 32'd0);
      repeat (PLS + 10) @(negedge clk);
      check("R5 idle high", 32'(kbd_rst_n), 32'd1);

      repeat (4) @(negedge clk);
      check("R7 all reads compared", 32'(exp_q.size()), 32'd0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

endmodule